// File: doc/BRIEF.md
# Multi-mode 24-bit position counter

This block holds the position count for an incremental encoder channel. A quadrature decoder elsewhere supplies a count strobe and a direction bit. Each strobe moves a 24-bit register up or down by one. The register counts either in plain binary or as six packed decimal digits. When the count runs past its limit it either wraps around or, in divide-by-N mode, reloads from a software-written preset.

The block reports carry and borrow as one-cycle pulses. It keeps toggle flags for carry, borrow and preset-compare, and it also keeps a sign bit and a direction bit. Two real-time output pins share a single 2-bit mode field that chooses what both of them show.

A bus decoder elsewhere turns register writes into the mode bits and into single-cycle command pulses. The commands clear the count, load the preset, snapshot the count into a readable latch, and clear the compare flag.

Top module: `pos_counter`

## Requirements
- R1: In binary mode (`bcd_i`=0) each cycle with `cnt_en_i` high changes the count by one: up when `cnt_up_i`=1, down when it is 0. Counting up from 0xFFFFFF gives 0 and counting down from 0 gives 0xFFFFFF. A wrap raises `carry_o` (on the way up) or `borrow_o` (on the way down) for exactly the following cycle. Without a strobe or command the count holds.
- R2: In decimal mode (`bcd_i`=1) each nibble is one decimal digit, and bits 3:0 hold the least significant digit. The count runs 000000..999999, and passing either end wraps to the other end with a carry or borrow pulse.
- R3: With `div_n_i`=1, a count step that would wrap loads the preset value instead, and it still raises carry or borrow.
- R4: `carry_tgl_o` and `borrow_tgl_o` come out of reset low. Each one inverts on the clock edge that ends its pulse, which is one cycle after the pulse is seen. `cmd_clr_i` clears both.
- R5: `sign_o` is high after reset and after `cmd_clr_i`. It goes high on a carry and low on a borrow, in the same cycle the pulse appears.
- R6: `dir_o` takes the value of `cnt_up_i` on every strobe cycle and holds it between strobes. It is high after reset.
- R7: `match_o` is high exactly while the count equals the preset. `cmp_tgl_o` inverts on the edge after a match period ends. Only `cmd_cmp_clr_i` or reset clears it.
- R8: `cmd_latch_i` copies the whole count, as it stood before that clock edge, into `latch_o`. `latch_o` holds its value at all other times.
- R9: `pin_mode_i` drives both pins together:
  - 00: `pin_a_o`=~carry, `pin_b_o`=~borrow.
  - 01: the carry and borrow toggle flags.
  - 10: carry and borrow, active high.
  - 11: `pin_a_o`=~match and `pin_b_o`=match.
- R10: Commands come before counting. `cmd_clr_i` beats `cmd_load_i`, and `cmd_load_i` beats a strobe. A cycle taken by a command produces no carry or borrow. A load uses the preset held before the edge, even when `preset_we_i` writes a new value in the same cycle.
- R11: After reset the count, preset, latch, pulses and all toggle flags are zero, while sign and direction are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count strobe from the quadrature decoder |
| cnt_up_i | input | 1 | Count direction, 1 = up |
| bcd_i | input | 1 | 1 = six-digit decimal counting |
| div_n_i | input | 1 | 1 = reload from preset on wrap |
| pin_mode_i | input | 2 | Mode of both real-time pins |
| preset_we_i | input | 1 | Write `preset_i` into the preset register |
| preset_i | input | 24 | New preset value |
| cmd_clr_i | input | 1 | Clear count, carry/borrow toggles; set sign |
| cmd_load_i | input | 1 | Copy preset into count |
| cmd_latch_i | input | 1 | Snapshot count into output latch |
| cmd_cmp_clr_i | input | 1 | Clear compare toggle flag |
| count_o | output | 24 | Live count |
| latch_o | output | 24 | Output latch |
| carry_o | output | 1 | Carry pulse |
| borrow_o | output | 1 | Borrow pulse |
| match_o | output | 1 | Count equals preset |
| carry_tgl_o | output | 1 | Carry toggle flag |
| borrow_tgl_o | output | 1 | Borrow toggle flag |
| cmp_tgl_o | output | 1 | Compare toggle flag |
| sign_o | output | 1 | Sign bit |
| dir_o | output | 1 | Last count direction |
| pin_a_o | output | 1 | Real-time pin A |
| pin_b_o | output | 1 | Real-time pin B |

## Verification
The wrap points are the hard part to reach, because a count of 2^24 or 10^6 steps is too long to walk. The stimulus first writes a preset a few steps short of either limit and loads it, then strobes across the boundary. This is done in binary and decimal mode, with and without reload, and in every pin mode. A match that ends on the same step as a reload, and commands arriving together with a wrapping strobe, are reached the same way. A long random phase then keeps presets near the limits so that these collisions keep happening.

// File: rtl/pos_cnt_pkg.sv
package pos_cnt_pkg;
  typedef enum logic [1:0] {
    PIN_CB_LOW  = 2'b00,
    PIN_CB_TGL  = 2'b01,
    PIN_CB_HIGH = 2'b10,
    PIN_MATCH   = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/pos_cnt_step.sv
module pos_cnt_step #(
  parameter int DIGITS      = 6,
  parameter bit BCD_SUPPORT = 1'b1,
  localparam int W          = 4 * DIGITS
) (
  input  logic [W-1:0] val_i,
  input  logic         up_i,
  input  logic         bcd_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  logic [W-1:0] bin_nxt, bcd_nxt;
  logic         bin_wrap, bcd_wrap;

  assign bin_nxt  = up_i ? val_i + 1'b1 : val_i - 1'b1;
  assign bin_wrap = up_i ? &val_i : ~|val_i;

  generate
    if (BCD_SUPPORT) begin : g_bcd
      logic [3:0] dig, ndig;
      logic       cy;
      // ripple a +/-1 through the decimal digits
      always_comb begin
        cy      = 1'b1;
        bcd_nxt = '0;
        dig     = '0;
        ndig    = '0;
        for (int i = 0; i < DIGITS; i++) begin
          dig  = val_i[4*i +: 4];
          ndig = dig;
          if (cy) begin
            if (up_i) begin
              if (dig >= 4'd9) ndig = 4'd0;
              else begin ndig = dig + 4'd1; cy = 1'b0; end
            end else begin
              if (dig == 4'd0) ndig = 4'd9;
              else begin ndig = dig - 4'd1; cy = 1'b0; end
            end
          end
          bcd_nxt[4*i +: 4] = ndig;
        end
        bcd_wrap = cy;
      end
    end else begin : g_nobcd
      assign bcd_nxt  = bin_nxt;
      assign bcd_wrap = bin_wrap;
    end
  endgenerate

  assign nxt_o  = bcd_i ? bcd_nxt : bin_nxt;
  assign wrap_o = bcd_i ? bcd_wrap : bin_wrap;
endmodule

// File: rtl/pos_cnt_flags.sv
module pos_cnt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carry_evt_i,
  input  logic borrow_evt_i,
  input  logic clr_i,
  input  logic match_i,
  input  logic cmp_clr_i,
  input  logic cnt_en_i,
  input  logic cnt_up_i,
  output logic carry_o,
  output logic borrow_o,
  output logic carry_tgl_o,
  output logic borrow_tgl_o,
  output logic cmp_tgl_o,
  output logic sign_o,
  output logic dir_o
);
  logic match_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_o      <= 1'b0;
      borrow_o     <= 1'b0;
      carry_tgl_o  <= 1'b0;
      borrow_tgl_o <= 1'b0;
      cmp_tgl_o    <= 1'b0;
      sign_o       <= 1'b1;
      dir_o        <= 1'b1;
      match_prev_q <= 1'b0;
    end else begin
      carry_o  <= carry_evt_i;
      borrow_o <= borrow_evt_i;
      if (clr_i) begin
        carry_tgl_o  <= 1'b0;
        borrow_tgl_o <= 1'b0;
        sign_o       <= 1'b1;
      end else begin
        // trailing edge of the pulse
        carry_tgl_o  <= carry_tgl_o ^ carry_o;
        borrow_tgl_o <= borrow_tgl_o ^ borrow_o;
        if (carry_evt_i)       sign_o <= 1'b1;
        else if (borrow_evt_i) sign_o <= 1'b0;
      end
      if (cnt_en_i) dir_o <= cnt_up_i;
      match_prev_q <= match_i;
      if (cmp_clr_i)                    cmp_tgl_o <= 1'b0;
      else if (match_prev_q && !match_i) cmp_tgl_o <= ~cmp_tgl_o;
    end
  end

  AST_CB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(carry_o && borrow_o)); // R1
  AST_SIGN_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> sign_o); // R5
  AST_SIGN_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    borrow_o |-> !sign_o); // R5
  AST_CTGL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o && !clr_i |=> carry_tgl_o != $past(carry_tgl_o)); // R4
  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_clr_i && !(match_prev_q && !match_i) |=> $stable(cmp_tgl_o)); // R7
endmodule

// File: rtl/pos_cnt_pins.sv
module pos_cnt_pins
  import pos_cnt_pkg::*;
(
  input  pin_mode_e mode_i,
  input  logic      carry_i,
  input  logic      borrow_i,
  input  logic      carry_tgl_i,
  input  logic      borrow_tgl_i,
  input  logic      match_i,
  output logic      pin_a_o,
  output logic      pin_b_o
);
  always_comb begin
    unique case (mode_i)
      PIN_CB_LOW:  begin pin_a_o = ~carry_i;     pin_b_o = ~borrow_i;     end
      PIN_CB_TGL:  begin pin_a_o = carry_tgl_i;  pin_b_o = borrow_tgl_i;  end
      PIN_CB_HIGH: begin pin_a_o = carry_i;      pin_b_o = borrow_i;      end
      default:     begin pin_a_o = ~match_i;     pin_b_o = match_i;       end
    endcase
  end
endmodule

// File: rtl/pos_counter.sv
module pos_counter
  import pos_cnt_pkg::*;
#(
  parameter int DIGITS      = 6,
  parameter bit BCD_SUPPORT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cnt_en_i,
  input  logic                  cnt_up_i,
  input  logic                  bcd_i,
  input  logic                  div_n_i,
  input  logic [1:0]            pin_mode_i,
  input  logic                  preset_we_i,
  input  logic [4*DIGITS-1:0]   preset_i,
  input  logic                  cmd_clr_i,
  input  logic                  cmd_load_i,
  input  logic                  cmd_latch_i,
  input  logic                  cmd_cmp_clr_i,
  output logic [4*DIGITS-1:0]   count_o,
  output logic [4*DIGITS-1:0]   latch_o,
  output logic                  carry_o,
  output logic                  borrow_o,
  output logic                  match_o,
  output logic                  carry_tgl_o,
  output logic                  borrow_tgl_o,
  output logic                  cmp_tgl_o,
  output logic                  sign_o,
  output logic                  dir_o,
  output logic                  pin_a_o,
  output logic                  pin_b_o
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] cnt_q, cnt_d, preset_q, latch_q, step_nxt;
  logic         step_wrap, count_ev, carry_evt, borrow_evt;

  pos_cnt_step #(.DIGITS(DIGITS), .BCD_SUPPORT(BCD_SUPPORT)) u_step (
    .val_i (cnt_q),
    .up_i  (cnt_up_i),
    .bcd_i (bcd_i),
    .nxt_o (step_nxt),
    .wrap_o(step_wrap)
  );

  assign count_ev   = cnt_en_i && !cmd_clr_i && !cmd_load_i;
  assign carry_evt  = count_ev && cnt_up_i && step_wrap;
  assign borrow_evt = count_ev && !cnt_up_i && step_wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_clr_i)       cnt_d = '0;
    else if (cmd_load_i) cnt_d = preset_q;
    else if (count_ev)   cnt_d = (step_wrap && div_n_i) ? preset_q : step_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      preset_q <= '0;
      latch_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (preset_we_i) preset_q <= preset_i;
      if (cmd_latch_i) latch_q  <= cnt_q;
    end
  end

  assign match_o = (cnt_q == preset_q);
  assign count_o = cnt_q;
  assign latch_o = latch_q;

  pos_cnt_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .carry_evt_i (carry_evt),
    .borrow_evt_i(borrow_evt),
    .clr_i       (cmd_clr_i),
    .match_i     (match_o),
    .cmp_clr_i   (cmd_cmp_clr_i),
    .cnt_en_i    (cnt_en_i),
    .cnt_up_i    (cnt_up_i),
    .carry_o     (carry_o),
    .borrow_o    (borrow_o),
    .carry_tgl_o (carry_tgl_o),
    .borrow_tgl_o(borrow_tgl_o),
    .cmp_tgl_o   (cmp_tgl_o),
    .sign_o      (sign_o),
    .dir_o       (dir_o)
  );

  pos_cnt_pins u_pins (
    .mode_i      (pin_mode_e'(pin_mode_i)),
    .carry_i     (carry_o),
    .borrow_i    (borrow_o),
    .carry_tgl_i (carry_tgl_o),
    .borrow_tgl_i(borrow_tgl_o),
    .match_i     (match_o),
    .pin_a_o     (pin_a_o),
    .pin_b_o     (pin_b_o)
  );

  AST_CLR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_clr_i |=> cnt_q == '0 && !carry_o && !borrow_o); // R10
  AST_LOAD_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_clr_i && cmd_load_i |=> cnt_q == $past(preset_q) && !carry_o && !borrow_o); // R10
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i && !cmd_clr_i && !cmd_load_i |=> $stable(cnt_q)); // R1
  AST_LATCH_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_latch_i |=> latch_q == $past(cnt_q)); // R8
  AST_DIVN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_n_i && (carry_evt || borrow_evt) |=> cnt_q == $past(preset_q)); // R3
  AST_PIN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_mode_i == 2'b11 |-> pin_b_o == match_o && pin_a_o == !match_o); // R9
endmodule

// File: tb/tb_pos_counter.sv
module tb_pos_counter;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_en = 0, cnt_up = 0, bcd = 0, div_n = 0, preset_we = 0;
  logic [1:0] pin_mode = 2'b00;
  logic [23:0] preset_in = '0;
  logic cmd_clr = 0, cmd_load = 0, cmd_latch = 0, cmd_cmp_clr = 0;

  logic [23:0] count_o, latch_o;
  logic carry_o, borrow_o, match_o, carry_tgl_o, borrow_tgl_o, cmp_tgl_o;
  logic sign_o, dir_o, pin_a_o, pin_b_o;

  always #10 clk = ~clk;

  pos_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en), .cnt_up_i(cnt_up),
    .bcd_i(bcd), .div_n_i(div_n), .pin_mode_i(pin_mode),
    .preset_we_i(preset_we), .preset_i(preset_in),
    .cmd_clr_i(cmd_clr), .cmd_load_i(cmd_load), .cmd_latch_i(cmd_latch),
    .cmd_cmp_clr_i(cmd_cmp_clr),
    .count_o(count_o), .latch_o(latch_o), .carry_o(carry_o), .borrow_o(borrow_o),
    .match_o(match_o), .carry_tgl_o(carry_tgl_o), .borrow_tgl_o(borrow_tgl_o),
    .cmp_tgl_o(cmp_tgl_o), .sign_o(sign_o), .dir_o(dir_o),
    .pin_a_o(pin_a_o), .pin_b_o(pin_b_o)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R11";

  // reference state
  logic [23:0] m_cnt, m_pre, m_lat;
  logic m_ca, m_bo, m_ctgl, m_btgl, m_mtgl, m_mprev, m_sign, m_dir;

  function automatic int dec_v(logic [23:0] x, logic b);
    int v = 0;
    if (!b) return int'(x);
    for (int i = 5; i >= 0; i--) v = v * 10 + int'(x[4*i +: 4]);
    return v;
  endfunction

  function automatic logic [23:0] enc_v(int v, logic b);
    logic [23:0] r = '0;
    if (!b) return v[23:0];
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_pre = '0; m_lat = '0; m_ca = 0; m_bo = 0;
    m_ctgl = 0; m_btgl = 0; m_mtgl = 0; m_mprev = 0; m_sign = 1; m_dir = 1;
  endtask

  task automatic model_step();
    logic [23:0] nc = m_cnt;
    logic nca = 0, nbo = 0, m;
    int v, mx;
    m  = (m_cnt == m_pre);
    mx = bcd ? 999999 : 16777215;
    if (cmd_clr) nc = '0;
    else if (cmd_load) nc = m_pre;
    else if (cnt_en) begin
      v = dec_v(m_cnt, bcd);
      if (cnt_up) begin
        if (v == mx) begin nca = 1; nc = div_n ? m_pre : '0; end
        else nc = enc_v(v + 1, bcd);
      end else begin
        if (v == 0) begin nbo = 1; nc = div_n ? m_pre : enc_v(mx, bcd); end
        else nc = enc_v(v - 1, bcd);
      end
    end
    if (cmd_clr) begin m_ctgl = 0; m_btgl = 0; m_sign = 1; end
    else begin
      m_ctgl ^= m_ca; m_btgl ^= m_bo;
      if (nca) m_sign = 1; else if (nbo) m_sign = 0;
    end
    if (cnt_en) m_dir = cnt_up;
    if (cmd_cmp_clr) m_mtgl = 0; else if (m_mprev && !m) m_mtgl ^= 1;
    m_mprev = m;
    if (cmd_latch) m_lat = m_cnt;
    if (preset_we) m_pre = preset_in;
    m_cnt = nc; m_ca = nca; m_bo = nbo;
  endtask

  task automatic chk(string req, string nm, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic m = (m_cnt == m_pre);
    logic ea, eb;
    case (pin_mode)
      2'b00: begin ea = !m_ca; eb = !m_bo; end
      2'b01: begin ea = m_ctgl; eb = m_btgl; end
      2'b10: begin ea = m_ca; eb = m_bo; end
      default: begin ea = !m; eb = m; end
    endcase
    chk(tag, "count", count_o, m_cnt);
    chk("R8", "latch", latch_o, m_lat);
    chk("R1", "carry", 24'(carry_o), 24'(m_ca));
    chk("R1", "borrow", 24'(borrow_o), 24'(m_bo));
    chk("R4", "carry_tgl", 24'(carry_tgl_o), 24'(m_ctgl));
    chk("R4", "borrow_tgl", 24'(borrow_tgl_o), 24'(m_btgl));
    chk("R7", "match", 24'(match_o), 24'(m));
    chk("R7", "cmp_tgl", 24'(cmp_tgl_o), 24'(m_mtgl));
    chk("R5", "sign", 24'(sign_o), 24'(m_sign));
    chk("R6", "dir", 24'(dir_o), 24'(m_dir));
    chk("R9", "pin_a", 24'(pin_a_o), 24'(ea));
    chk("R9", "pin_b", 24'(pin_b_o), 24'(eb));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
    cmd_clr = 0; cmd_load = 0; cmd_latch = 0; cmd_cmp_clr = 0; preset_we = 0;
  endtask

  task automatic set_preset(logic [23:0] v);
    preset_in = v; preset_we = 1; cnt_en = 0; tick();
    cmd_load = 1; tick();
  endtask

  task automatic run(logic up, int n);
    cnt_en = 1; cnt_up = up;
    for (int i = 0; i < n; i++) tick();
    cnt_en = 0; tick(); tick();
  endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    tag = "R11";                        // reset state
    compare();

    // R1 binary wrap in every pin mode (R9)
    for (int md = 0; md < 4; md++) begin
      tag = "R1"; pin_mode = md[1:0];
      set_preset(24'hFFFFFD); run(1, 5);
      set_preset(24'h000002); run(0, 5);
    end

    // R3 divide-by-N reload
    tag = "R3"; div_n = 1; pin_mode = 2'b10;
    set_preset(24'h000003); run(0, 9);
    set_preset(24'hFFFFFE); run(1, 6);
    div_n = 0;

    // R2 decimal counting
    tag = "R2"; bcd = 1; cmd_clr = 1; preset_in = 24'h999997; preset_we = 1; tick();
    cmd_load = 1; tick(); run(1, 6);
    set_preset(24'h000002); run(0, 5);
    set_preset(24'h000098); run(1, 4);
    set_preset(24'h010000); run(0, 2);
    div_n = 1; set_preset(24'h000005); run(0, 8); div_n = 0;
    tag = "R1"; bcd = 0; cmd_clr = 1; tick();

    // R7 match and compare flag
    tag = "R7"; pin_mode = 2'b11;
    set_preset(24'h000005); cmd_clr = 1; tick();
    run(1, 8); run(0, 4);
    cmd_cmp_clr = 1; tick(); run(1, 3);

    // R10 command priority
    tag = "R10";
    set_preset(24'hFFFFFF);
    cnt_en = 1; cnt_up = 1; cmd_clr = 1; cmd_load = 1; tick();
    cmd_load = 1; tick();
    cmd_load = 1; preset_we = 1; preset_in = 24'h123456; tick();
    cnt_up = 0; tick(); cmd_load = 1; tick();
    cnt_en = 0; tick();

    // R8 latch during counting
    tag = "R8";
    cnt_en = 1; cnt_up = 1;
    for (int i = 0; i < 6; i++) begin cmd_latch = i[0]; tick(); end
    cnt_en = 0; tick();

    // R6 and mixed random traffic
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      cnt_en = $urandom_range(0, 3) != 0;
      cnt_up = $urandom_range(0, 1);
      pin_mode = 2'($urandom_range(0, 3));
      div_n = $urandom_range(0, 1);
      if (r < 2) begin
        bcd = ~bcd; cmd_clr = 1; preset_we = 1;
        preset_in = bcd ? enc_v(999996, 1'b1) : 24'hFFFFFC;
      end else if (r < 6) begin
        preset_we = 1;
        if ($urandom_range(0, 1)) preset_in = enc_v($urandom_range(0, 4), bcd);
        else preset_in = bcd ? enc_v(999999 - $urandom_range(0, 4), 1'b1)
                             : 24'hFFFFFF - 24'($urandom_range(0, 4));
      end else if (r < 9) cmd_load = 1;
      else if (r < 10) cmd_clr = 1;
      else if (r < 14) cmd_latch = 1;
      else if (r < 16) cmd_cmp_clr = 1;
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule